// File: doc/BRIEF.md
# Grouped Event Selection Matrix

This block turns a large field of raw event lines into one increment pulse per performance counter per cycle. The raw lines form a grid of 256 row codes by 8 group columns. Software picks one row per column through a single 64-bit selection register, so a column can watch only one row at a time. Each counter has a type register naming the column it follows and a filter register that admits or rejects the event according to the subunit and originating CPU that raised it. A separate cycle line feeds a dedicated cycle-counter pulse.

The counters themselves sit outside this block; they add one whenever their pulse is high. All configuration arrives through a simple write port (enable, 12-bit address, 64-bit data). Every pulse is registered, so it appears one cycle after the raw line that caused it.

Top module: `evsel_matrix`

## Requirements
- R1: The selection register is written at address 0x410; group g's row code is bits 8g+7..8g, and raw line g*256+code (`raw_evt` index) is the line watched for group g. In identifiers the row is bits 11:4 and the group bits 3:0 (0x400 is row 0x40 group 0, 0x405 is row 0x40 group 5).
- R2: Bit 63 of the selection register enables selection; while it is 0 no `ctr_inc` bit and no `cyc_inc` pulse is raised, whatever the other settings.
- R3: Group 7's row code is bits 62:56 with its top bit taken as 0, so group 7 can watch only rows 0..127.
- R4: Counter c's type register is at address 0x500+c, bits 2:0 holding the group; the counter follows the row selected for that group, and counters with the same group pulse together.
- R5: Counter c's filter register is at 0x540+c: bits 19:17 enable subunits 0..2 (subunit k at bit 17+k), bit 2 admits CPU-independent events, bits 1:0 admit CPUs 0 and 1. A CPU-independent event passes if bit 2 is set; any other passes if its CPU bit is enabled. The event's subunit must also be enabled.
- R6: A pulse appears in the cycle after the raw line is sampled high and never in the same cycle.
- R7: `cyc_inc` follows `cyc_evt` one cycle later while selection is enabled; the cycle line never drives `ctr_inc`.
- R8: Reset (synchronous, active low) clears all configuration and both outputs.
- R9: Writes to addresses that are not a selection, type or filter register change nothing.
- R10: A raw line in a group that is not the selected row produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| raw_evt | input | 2048 | Raw event lines, index group*256+row |
| evt_sub | input | 24 | Per group, 3-bit subunit of this cycle's event |
| evt_cpu | input | 16 | Per group, 2-bit originating CPU of this cycle's event |
| evt_indep | input | 8 | Per group, event is independent of CPU ID |
| cyc_evt | input | 1 | Cycle event line |
| ctr_inc | output | 8 | Registered increment pulse per event counter |
| cyc_inc | output | 1 | Registered increment pulse for the cycle counter |

## Verification
A corrupted row code or type field shows at the ports as a pulse on the wrong counter, or a missing one, in the cycle after the first raw event that exercises it, so the bench pairs each configuration with events on both the selected and a neighbouring row. A wrong filter bit shows only when the event carries the attribute that bit decides, so each attribute (subunit, CPU, CPU-independence) is driven against a filter that differs from it in that bit alone. A lost enable bit shows as pulses during a disabled phase, checked with every raw line high.

// File: rtl/evsel_pkg.sv
// Shared constants and types for the grouped event selection matrix.
// Assumes the filter register layout is fixed: subunit enables 19:17,
// CPU-independent bit 2, CPU enables 1:0.
package evsel_pkg;
    localparam int SUB_W     = 3;
    localparam int CPU_W     = 2;
    localparam int FILT_W    = SUB_W + 1 + CPU_W;
    localparam int SEL_ADDR  = 'h410;
    localparam int TYPE_BASE = 'h500;
    localparam int FILT_BASE = 'h540;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic             indep;
        logic [CPU_W-1:0] cpu;
    } filt_t;
endpackage

// File: rtl/evsel_sel_reg.sv
// Row selection register: one row code per group plus a global enable
// in the top bit. Assumes NUM_GRP*CODE_W equals the register width.
module evsel_sel_reg #(
    parameter int NUM_GRP = 8,
    parameter int CODE_W  = 8,
    parameter int ADDR_W  = 12,
    localparam int SEL_W  = NUM_GRP * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  wdata,
    output logic              sel_en,
    output logic [SEL_W-1:0]  codes
);
    import evsel_pkg::*;

    logic [SEL_W-1:0] sel_q;

    // Capture the whole register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (we && addr == ADDR_W'(SEL_ADDR))
            sel_q <= wdata;
    end

    // The enable bit is not part of the last group's row code.
    assign sel_en = sel_q[SEL_W-1];
    assign codes  = {1'b0, sel_q[SEL_W-2:0]};
endmodule

// File: rtl/evsel_row_mux.sv
// Per group, picks the raw line of the selected row.
// Assumes raw lines are laid out group-major: index group*ROWS+row.
module evsel_row_mux #(
    parameter int NUM_GRP = 8,
    parameter int CODE_W  = 8,
    localparam int ROWS   = 1 << CODE_W
) (
    input  logic [NUM_GRP*ROWS-1:0]   raw_evt,
    input  logic [NUM_GRP*CODE_W-1:0] codes,
    output logic [NUM_GRP-1:0]        grp_hit
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [ROWS-1:0]   rows;
        logic [CODE_W-1:0] code;
        // Slice out this column and index it by its row code.
        assign rows       = raw_evt[g*ROWS +: ROWS];
        assign code       = codes[g*CODE_W +: CODE_W];
        assign grp_hit[g] = rows[code];
    end
endmodule

// File: rtl/evsel_ctr_cfg.sv
// Type and filter registers for every counter.
// Assumes type and filter addresses are BASE + counter index.
module evsel_ctr_cfg #(
    parameter int NUM_CTRS = 8,
    parameter int GRP_W    = 3,
    parameter int ADDR_W   = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [GRP_W-1:0]                      wr_type,
    input  evsel_pkg::filt_t                      wr_filt,
    output logic [NUM_CTRS*GRP_W-1:0]             type_all,
    output logic [NUM_CTRS*evsel_pkg::FILT_W-1:0] filt_all
);
    import evsel_pkg::*;

    for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
        localparam logic [ADDR_W-1:0] T_ADDR = ADDR_W'(TYPE_BASE + c);
        localparam logic [ADDR_W-1:0] F_ADDR = ADDR_W'(FILT_BASE + c);
        logic [GRP_W-1:0] type_q;
        filt_t            filt_q;

        // Hold this counter's group number and origin filter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                type_q <= '0;
                filt_q <= '0;
            end else if (we) begin
                if (addr == T_ADDR) type_q <= wr_type;
                if (addr == F_ADDR) filt_q <= wr_filt;
            end
        end

        assign type_all[c*GRP_W +: GRP_W]   = type_q;
        assign filt_all[c*FILT_W +: FILT_W] = filt_q;
    end
endmodule

// File: rtl/evsel_ctr_gate.sv
// Per counter: follows its group's selected line, applies the origin
// filter and the global enable, and registers the pulse. Also registers
// the cycle pulse. Assumes attributes are given per group column.
module evsel_ctr_gate #(
    parameter int NUM_GRP  = 8,
    parameter int NUM_CTRS = 8,
    parameter int GRP_W    = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sel_en,
    input  logic [NUM_GRP-1:0]                    grp_hit,
    input  logic [NUM_GRP*evsel_pkg::SUB_W-1:0]   evt_sub,
    input  logic [NUM_GRP*evsel_pkg::CPU_W-1:0]   evt_cpu,
    input  logic [NUM_GRP-1:0]                    evt_indep,
    input  logic [NUM_CTRS*GRP_W-1:0]             type_all,
    input  logic [NUM_CTRS*evsel_pkg::FILT_W-1:0] filt_all,
    input  logic                                  cyc_evt,
    output logic [NUM_CTRS-1:0]                   ctr_inc,
    output logic                                  cyc_inc
);
    import evsel_pkg::*;

    logic [NUM_CTRS-1:0] inc_d;

    for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
        logic [GRP_W-1:0] grp;
        filt_t            f;
        logic [SUB_W-1:0] sub;
        logic [CPU_W-1:0] cpu;
        logic             ind;
        logic             pass;

        // Gather the attributes of the followed group and test the filter.
        assign grp  = type_all[c*GRP_W +: GRP_W];
        assign f    = filt_t'(filt_all[c*FILT_W +: FILT_W]);
        assign sub  = evt_sub[grp*SUB_W +: SUB_W];
        assign cpu  = evt_cpu[grp*CPU_W +: CPU_W];
        assign ind  = evt_indep[grp];
        assign pass = (|(sub & f.sub)) && (ind ? f.indep : |(cpu & f.cpu));
        assign inc_d[c] = sel_en && grp_hit[grp] && pass;
    end

    // Register all pulses so they leave one cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_inc <= '0;
            cyc_inc <= 1'b0;
        end else begin
            ctr_inc <= inc_d;
            cyc_inc <= sel_en && cyc_evt;
        end
    end
endmodule

// File: rtl/evsel_matrix.sv
// Top of the grouped event selection matrix: register file, per-group
// row selection and per-counter gating. Assumes a 64-bit selection word.
module evsel_matrix #(
    parameter int NUM_GRP  = 8,
    parameter int CODE_W   = 8,
    parameter int NUM_CTRS = 8,
    parameter int ADDR_W   = 12,
    localparam int ROWS    = 1 << CODE_W,
    localparam int SEL_W   = NUM_GRP * CODE_W,
    localparam int GRP_W   = $clog2(NUM_GRP)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [ADDR_W-1:0]                    cfg_addr,
    input  logic [SEL_W-1:0]                     cfg_wdata,
    input  logic [NUM_GRP*ROWS-1:0]              raw_evt,
    input  logic [NUM_GRP*evsel_pkg::SUB_W-1:0]  evt_sub,
    input  logic [NUM_GRP*evsel_pkg::CPU_W-1:0]  evt_cpu,
    input  logic [NUM_GRP-1:0]                   evt_indep,
    input  logic                                 cyc_evt,
    output logic [NUM_CTRS-1:0]                  ctr_inc,
    output logic                                 cyc_inc
);
    import evsel_pkg::*;

    logic                         sel_en;
    logic [SEL_W-1:0]             codes;
    logic [NUM_GRP-1:0]           grp_hit;
    logic [NUM_CTRS*GRP_W-1:0]    type_all;
    logic [NUM_CTRS*FILT_W-1:0]   filt_all;
    filt_t                        wr_filt;

    // Pick the filter fields out of the write data.
    assign wr_filt = '{sub: cfg_wdata[19:17], indep: cfg_wdata[2], cpu: cfg_wdata[1:0]};

    evsel_sel_reg #(.NUM_GRP(NUM_GRP), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .sel_en(sel_en), .codes(codes)
    );

    evsel_row_mux #(.NUM_GRP(NUM_GRP), .CODE_W(CODE_W)) u_mux (
        .raw_evt(raw_evt), .codes(codes), .grp_hit(grp_hit)
    );

    evsel_ctr_cfg #(.NUM_CTRS(NUM_CTRS), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wr_type(cfg_wdata[GRP_W-1:0]), .wr_filt(wr_filt),
        .type_all(type_all), .filt_all(filt_all)
    );

    evsel_ctr_gate #(.NUM_GRP(NUM_GRP), .NUM_CTRS(NUM_CTRS), .GRP_W(GRP_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .grp_hit(grp_hit),
        .evt_sub(evt_sub), .evt_cpu(evt_cpu), .evt_indep(evt_indep),
        .type_all(type_all), .filt_all(filt_all), .cyc_evt(cyc_evt),
        .ctr_inc(ctr_inc), .cyc_inc(cyc_inc)
    );
endmodule

// File: rtl/evsel_checker.sv
// Property checker for the event selection matrix, bound to its top.
// Assumes the filter vector packs subunit enables in each entry's top bits.
module evsel_checker #(
    parameter int NUM_CTRS = 8,
    parameter int RAW_W    = 2048
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  sel_en,
    input logic [RAW_W-1:0]                      raw_evt,
    input logic                                  cyc_evt,
    input logic [NUM_CTRS*evsel_pkg::FILT_W-1:0] filt_all,
    input logic [NUM_CTRS-1:0]                   ctr_inc,
    input logic                                  cyc_inc
);
    import evsel_pkg::*;

    // Outputs are quiet on the first cycle out of reset.
    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctr_inc == '0 && !cyc_inc));

    // A clear enable silences every pulse in the next cycle.
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> (ctr_inc == '0 && !cyc_inc));

    // A counter pulse needs some raw line high the cycle before.
    assert_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctr_inc) |-> $past(|raw_evt));

    // The cycle pulse comes only from the cycle line.
    assert_cycle_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_inc |-> $past(cyc_evt));

    for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
        // With no subunit enabled, the counter never pulses.
        assert_filter_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_all[c*FILT_W+FILT_W-1 -: SUB_W] == '0) |=> !ctr_inc[c]);
    end
endmodule

bind evsel_matrix evsel_checker #(.NUM_CTRS(NUM_CTRS), .RAW_W(NUM_GRP*ROWS)) i_chk (
    .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .raw_evt(raw_evt),
    .cyc_evt(cyc_evt), .filt_all(filt_all), .ctr_inc(ctr_inc), .cyc_inc(cyc_inc)
);

// File: tb/test_evsel_matrix.sv
// Directed bench for the grouped event selection matrix.
module test_evsel_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NGRP = 8;
    localparam int NCTR = 8;
    localparam int ROWS = 256;
    localparam logic [63:0] FILT_ALL = 64'h000E_0007;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [11:0]       cfg_addr = '0;
    logic [63:0]       cfg_wdata = '0;
    logic [NGRP*ROWS-1:0] raw_evt = '0;
    logic [NGRP*3-1:0] evt_sub;
    logic [NGRP*2-1:0] evt_cpu;
    logic [NGRP-1:0]   evt_indep = '0;
    logic              cyc_evt = 1'b0;
    logic [NCTR-1:0]   ctr_inc;
    logic              cyc_inc;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench copy of the configuration, kept from the requirements.
    logic [63:0] sh_sel = '0;
    logic [2:0]  sh_type [NCTR];
    logic [5:0]  sh_filt [NCTR];   // {sub[2:0], indep, cpu[1:0]}

    evsel_matrix i_evsel_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .raw_evt(raw_evt), .evt_sub(evt_sub),
        .evt_cpu(evt_cpu), .evt_indep(evt_indep), .cyc_evt(cyc_evt),
        .ctr_inc(ctr_inc), .cyc_inc(cyc_inc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Expected pulses from the current inputs and the bench configuration.
    function automatic logic [NCTR-1:0] model();
        logic [NCTR-1:0] r = '0;
        for (int c = 0; c < NCTR; c++) begin
            int g = sh_type[c];
            logic [7:0] code = (g == NGRP-1) ? {1'b0, sh_sel[62:56]} : sh_sel[g*8 +: 8];
            logic [2:0] s = evt_sub[g*3 +: 3];
            logic [1:0] u = evt_cpu[g*2 +: 2];
            logic [5:0] f = sh_filt[c];
            logic pass = (|(s & f[5:3])) && (evt_indep[g] ? f[2] : |(u & f[1:0]));
            r[c] = sh_sel[63] && raw_evt[g*ROWS + int'(code)] && pass;
        end
        return r;
    endfunction

    task automatic wr(logic [11:0] a, logic [63:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 12'h410) sh_sel = d;
        for (int c = 0; c < NCTR; c++) begin
            if (a == 12'h500 + c) sh_type[c] = d[2:0];
            if (a == 12'h540 + c) sh_filt[c] = {d[19:17], d[2], d[1:0]};
        end
        step();
        cfg_we = 1'b0;
    endtask

    // One event cycle: inputs already driven; check next cycle, then clear.
    task automatic fire(string req);
        logic [NCTR-1:0] e = model();
        logic ec = sh_sel[63] && cyc_evt;
        step();
        chk(req, 32'(ctr_inc), 32'(e));
        chk(req, 32'(cyc_inc), 32'(ec));
        raw_evt = '0; cyc_evt = 1'b0;
        step();
        chk(req, 32'(ctr_inc), 32'h0);
    endtask

    task automatic t_reset();
        chk("R8 reset ctr_inc", 32'(ctr_inc), 32'h0);
        chk("R8 reset cyc_inc", 32'(cyc_inc), 32'h0);
        raw_evt = '1; cyc_evt = 1'b1;
        fire("R8 R2 events after reset, selection off");
    endtask

    task automatic t_basic();
        for (int c = 0; c < NCTR; c++) wr(12'h540 + 12'(c), FILT_ALL);
        wr(12'h500, 64'd0);   // counter 0 -> group 0
        wr(12'h501, 64'd5);   // counter 1 -> group 5
        // row 0x40 in group 0 and group 5, enable set
        wr(12'h410, 64'h8000_4000_0000_0040);
        raw_evt[0*ROWS + 'h40] = 1'b1;          // id 0x400
        #1 chk("R6 no pulse in same cycle", 32'(ctr_inc), 32'h0);
        fire("R1 R6 group0 row 0x40");
        raw_evt[5*ROWS + 'h40] = 1'b1;          // id 0x405
        fire("R1 group5 row 0x40");
    endtask

    task automatic t_shared_group();
        wr(12'h502, 64'd0);   // counter 2 -> group 0 too
        raw_evt[0*ROWS + 'h42] = 1'b1;          // id 0x420, not selected
        fire("R10 unselected row in group 0");
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R4 two counters on group 0");
    endtask

    task automatic t_group7();
        wr(12'h507, 64'd7);
        wr(12'h410, 64'hFF00_0000_0000_0040);   // group7 code 0x7F, enabled
        raw_evt[7*ROWS + 'h7F] = 1'b1;
        fire("R3 group7 row 0x7f");
        raw_evt[7*ROWS + 'hFF] = 1'b1;
        fire("R3 group7 row 0xff not reachable");
    endtask

    task automatic t_filter();
        wr(12'h503, 64'd0);
        wr(12'h543, 64'h0004_0001);             // subunit 1, CPU 0 only
        evt_sub[2:0] = 3'b010; evt_cpu[1:0] = 2'b01;
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R5 subunit1 cpu0 passes");
        evt_cpu[1:0] = 2'b10;
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R5 cpu1 rejected");
        evt_cpu[1:0] = 2'b01; evt_sub[2:0] = 3'b001;
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R5 subunit0 rejected");
        evt_sub[2:0] = 3'b010; evt_indep[0] = 1'b1;
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R5 cpu-independent rejected without bit2");
        wr(12'h543, 64'h0004_0004);
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R5 cpu-independent admitted by bit2");
        evt_indep[0] = 1'b0; evt_sub[2:0] = 3'b001;
    endtask

    task automatic t_cycle_and_ignore();
        cyc_evt = 1'b1;
        fire("R7 cycle pulse, no event counter");
        wr(12'h411, 64'h0);                     // not a register
        wr(12'h5FF, 64'h0);
        raw_evt[0*ROWS + 'h40] = 1'b1;
        fire("R9 stray writes leave enable and row");
        wr(12'h410, 64'h0000_4000_0000_0040);   // enable cleared
        raw_evt = '1; cyc_evt = 1'b1;
        fire("R2 disabled with all lines high");
    endtask

    initial begin
        for (int c = 0; c < NCTR; c++) begin
            sh_type[c] = '0;
            sh_filt[c] = '0;
        end
        for (int g = 0; g < NGRP; g++) begin
            evt_sub[g*3 +: 3] = 3'b001;
            evt_cpu[g*2 +: 2] = 2'b01;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_shared_group();
        t_group7();
        t_filter();
        t_cycle_and_ignore();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule